// File: doc/BRIEF.md
# Biphase-check infrared frame decoder

The block takes a demodulated infrared line, where a high level means carrier present (a pulse) and a low level means no carrier (a space). It synchronises the line to the system clock and times each run of one level in microseconds, using an internal prescaler. It cuts every run into fixed time slots and steps a frame state machine once per accepted slot. A frame is a one-slot pulse header followed by 31 bit cells. Each cell is a check slot and then a data slot. The data bits are assembled most significant first into a 31-bit scancode.

At a fixed set of bit positions, the check slot carries redundancy. It must be a pulse exactly when the current data bit and the one before it are both zero. At every other position, the check slot must be a space. Any violation raises a one-cycle error strobe. The decoder then stays deaf to the line until it has seen a long space, so that it cannot decode the tail of a broken frame as a shorter code. A good frame ends with a space slot. The scancode is then registered and announced with a one-cycle valid strobe.

Top module: `ir_biphase_decoder`

## Requirements
- R1: After reset, code_o is all zeros and valid_o and error_o are low.
- R2: A run of either level yields one slot after SLOT_US/2 microseconds and one more slot after each further SLOT_US microseconds. A run shorter than SLOT_US/2 yields no slot and does not disturb the decoder.
- R3: A pulse slot while idle starts a frame and clears the assembled value. The following 31 data slots give the bits from bit 30 down to bit 0, where a space means 1 and a pulse means 0. The completed value appears on code_o with bit 30 first received.
- R4: At a bit position outside the check set, a pulse in the check slot raises error_o.
- R5: The check set is bits 30, 25, 24, 22, 21, 20, 19, 18, 17, 16, 14, 13, 12, 11, 10 and 9 (mask 31'h437F7E00). At these positions the check slot must be a pulse exactly when the current bit and the previously received bit are both 0, with a 0 assumed above bit 30. Any other check value raises error_o.
- R6: The slot after bit 0 must be a space. A pulse there raises error_o. A space, including the start of an idle line, raises valid_o for one cycle with the frame on code_o, and the decoder returns to idle.
- R7: After an error, all slots are ignored, with no valid_o and no further error_o, until a space run lasts longer than ERR_GAP_US microseconds. The decoder is then idle.
- R8: A high abort_i forces the idle state on the next cycle, including from the error state.
- R9: valid_o and error_o are single-cycle strobes and never high together. code_o changes only together with valid_o, so an erroneous frame leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| abort_i | input | 1 | Synchronous request to return to idle |
| ir_i | input | 1 | Demodulated line, 1 = pulse, 0 = space (asynchronous) |
| code_o | output | 31 | Last good scancode |
| valid_o | output | 1 | One-cycle strobe: code_o holds a new frame |
| error_o | output | 1 | One-cycle strobe: protocol violation |

## Verification
Frames with all ones, all zeros and mixed bits are sent. They exercise long merged runs, chains of check pulses and the trailing idle space that must count as the closing slot. A decoder that miscounts slots in a merged run would lose bit alignment and report a wrong code or an error. Single faults are injected into a non-check check slot, a check-position check slot and the closing slot. A design that skipped either check rule, or accepted a closing pulse, would emit a valid frame instead of one error.

After an error, a frame with only short spaces is sent straight away. It must be ignored, and the same sequence preceded by abort_i must decode. This catches a decoder that leaves the error state too early or that ignores the abort. A sub-half-slot glitch on an idle line must not start a frame. A decoder that took it as a header would sit mid-frame and corrupt the following good frame.

// File: rtl/ir_dec_pkg.sv
package ir_dec_pkg;
  localparam int CODE_W = 31;
  localparam int IDX_W  = $clog2(CODE_W);
  localparam logic [CODE_W-1:0] CHECK_MASK = 31'h437F7E00;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHK,
    ST_DAT,
    ST_DONE,
    ST_ERR
  } dec_state_e;

  function automatic logic is_chk_pos(logic [IDX_W-1:0] idx);
    return CHECK_MASK[idx];
  endfunction
endpackage

// File: rtl/ir_line_sync.sv
module ir_line_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ir_i,
  output logic lvl_o,
  output logic edge_o
);
  logic [1:0] meta_q;
  logic       prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= {meta_q[0], ir_i};
      prev_q <= meta_q[1];
    end
  end

  assign lvl_o  = meta_q[1];
  assign edge_o = meta_q[1] ^ prev_q;
endmodule

// File: rtl/ir_slot_timer.sv
module ir_slot_timer #(
  parameter int CLKS_PER_US = 1,
  parameter int SLOT_US     = 416,
  parameter int ERR_GAP_US  = 10000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic edge_i,
  output logic slot_o,
  output logic slot_lvl_o,
  output logic gap_o
);
  localparam int HALF_US = SLOT_US / 2;
  localparam int UW      = $clog2(SLOT_US + 1);
  localparam int RW      = $clog2(ERR_GAP_US + 2);

  logic tick;

  generate
    if (CLKS_PER_US > 1) begin : g_presc
      localparam int PW = $clog2(CLKS_PER_US);
      logic [PW-1:0] pcnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                              pcnt_q <= '0;
        else if (pcnt_q == PW'(CLKS_PER_US - 1))  pcnt_q <= '0;
        else                                      pcnt_q <= pcnt_q + 1'b1;
      end
      assign tick = (pcnt_q == PW'(CLKS_PER_US - 1));
    end else begin : g_nopresc
      assign tick = 1'b1;
    end
  endgenerate

  logic [UW-1:0] ucnt_q, ucnt_nx;
  logic [RW-1:0] rcnt_q;
  logic          slot_q, slot_lvl_q, gap_q;

  assign ucnt_nx = (ucnt_q == UW'(SLOT_US - 1)) ? '0 : ucnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ucnt_q     <= '0;
      rcnt_q     <= '0;
      slot_q     <= 1'b0;
      slot_lvl_q <= 1'b0;
      gap_q      <= 1'b0;
    end else begin
      slot_q     <= 1'b0;
      gap_q      <= 1'b0;
      slot_lvl_q <= lvl_i;
      if (edge_i) begin
        ucnt_q <= '0;
        rcnt_q <= '0;
      end else if (tick) begin
        ucnt_q <= ucnt_nx;
        slot_q <= (ucnt_nx == UW'(HALF_US));
        if (rcnt_q != RW'(ERR_GAP_US + 1)) rcnt_q <= rcnt_q + 1'b1;
        gap_q  <= !lvl_i && (rcnt_q == RW'(ERR_GAP_US));
      end
    end
  end

  assign slot_o     = slot_q;
  assign slot_lvl_o = slot_lvl_q;
  assign gap_o      = gap_q;

  p_slot_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_o |=> !slot_o);
  p_gap_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_o |=> !gap_o);
  p_gap_space_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_o |-> !slot_lvl_o);
endmodule

// File: rtl/ir_frame_fsm.sv
module ir_frame_fsm
  import ir_dec_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              abort_i,
  input  logic              slot_i,
  input  logic              lvl_i,
  input  logic              gap_i,
  output logic [CODE_W-1:0] code_o,
  output logic              valid_o,
  output logic              error_o
);
  dec_state_e        state_q, state_d;
  logic [CODE_W-1:0] sh_q, sh_d, nsh, code_q, code_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              chk_q, chk_d, val_q, val_d, err_q, err_d;

  assign nsh = {sh_q[CODE_W-2:0], ~lvl_i};

  always_comb begin
    state_d = state_q;
    sh_d    = sh_q;
    idx_d   = idx_q;
    chk_d   = chk_q;
    code_d  = code_q;
    val_d   = 1'b0;
    err_d   = 1'b0;
    if (abort_i) begin
      state_d = ST_IDLE;
    end else if (state_q == ST_ERR) begin
      if (gap_i) state_d = ST_IDLE;
    end else if (slot_i) begin
      unique case (state_q)
        ST_IDLE: if (lvl_i) begin
          sh_d    = '0;
          idx_d   = IDX_W'(CODE_W - 1);
          state_d = ST_CHK;
        end
        ST_CHK: begin
          if (is_chk_pos(idx_q)) begin
            chk_d   = lvl_i;
            state_d = ST_DAT;
          end else if (lvl_i) begin
            state_d = ST_ERR;
            err_d   = 1'b1;
          end else begin
            state_d = ST_DAT;
          end
        end
        ST_DAT: begin
          sh_d = nsh;
          if (is_chk_pos(idx_q) && (chk_q != ~(nsh[1] | nsh[0]))) begin
            state_d = ST_ERR;
            err_d   = 1'b1;
          end else if (idx_q == '0) begin
            state_d = ST_DONE;
          end else begin
            idx_d   = idx_q - 1'b1;
            state_d = ST_CHK;
          end
        end
        ST_DONE: begin
          if (lvl_i) begin
            state_d = ST_ERR;
            err_d   = 1'b1;
          end else begin
            code_d  = sh_q;
            val_d   = 1'b1;
            state_d = ST_IDLE;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sh_q    <= '0;
      idx_q   <= '0;
      chk_q   <= 1'b0;
      code_q  <= '0;
      val_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      sh_q    <= sh_d;
      idx_q   <= idx_d;
      chk_q   <= chk_d;
      code_q  <= code_d;
      val_q   <= val_d;
      err_q   <= err_d;
    end
  end

  assign code_o  = code_q;
  assign valid_o = val_q;
  assign error_o = err_q;

  p_strobe_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && error_o));
  p_code_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(code_o) |-> valid_o);
  p_valid_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (state_q == ST_IDLE || state_q == ST_CHK));
  p_err_enter_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> (state_q == ST_ERR || state_q == ST_IDLE));
  p_err_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ERR && !abort_i) |=> !error_o && !valid_o);
  p_abort_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (state_q == ST_IDLE) && !valid_o && !error_o);
endmodule

// File: rtl/ir_biphase_decoder.sv
module ir_biphase_decoder
  import ir_dec_pkg::*;
#(
  parameter int CLKS_PER_US = 100,
  parameter int SLOT_US     = 416,
  parameter int ERR_GAP_US  = 10000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              abort_i,
  input  logic              ir_i,
  output logic [CODE_W-1:0] code_o,
  output logic              valid_o,
  output logic              error_o
);
  logic lvl, edge_det, slot, slot_lvl, gap;

  ir_line_sync u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ir_i   (ir_i),
    .lvl_o  (lvl),
    .edge_o (edge_det)
  );

  ir_slot_timer #(
    .CLKS_PER_US (CLKS_PER_US),
    .SLOT_US     (SLOT_US),
    .ERR_GAP_US  (ERR_GAP_US)
  ) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lvl_i      (lvl),
    .edge_i     (edge_det),
    .slot_o     (slot),
    .slot_lvl_o (slot_lvl),
    .gap_o      (gap)
  );

  ir_frame_fsm u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .abort_i (abort_i),
    .slot_i  (slot),
    .lvl_i   (slot_lvl),
    .gap_i   (gap),
    .code_o  (code_o),
    .valid_o (valid_o),
    .error_o (error_o)
  );
endmodule

// File: tb/ir_biphase_decoder_tb.sv
module ir_biphase_decoder_tb_top;
  localparam int CPU      = 2;
  localparam int SLOT     = 16;
  localparam int GAP      = 200;
  localparam int SLOT_CYC = SLOT * CPU;
  localparam logic [30:0] MASK = 31'h437F7E00;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        abort = 1'b0;
  logic        ir = 1'b0;
  logic [30:0] code;
  logic        valid, error;

  int n_chk = 0, n_fail = 0, n_valid = 0, n_err = 0, cyc = 0;
  logic [30:0] cap = '0;
  logic        frm [64];

  always #5 clk = ~clk;

  ir_biphase_decoder #(.CLKS_PER_US(CPU), .SLOT_US(SLOT), .ERR_GAP_US(GAP)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .abort_i(abort), .ir_i(ir),
    .code_o(code), .valid_o(valid), .error_o(error)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (valid) begin n_valid <= n_valid + 1; cap <= code; end
    if (error) n_err <= n_err + 1;
  end

  task automatic check(input logic ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic lvl, input int cycles);
    ir = lvl;
    repeat (cycles) @(negedge clk);
  endtask

  task automatic build(input logic [30:0] c);
    logic [31:0] cx;
    cx = {1'b0, c};
    frm[0] = 1'b1;
    for (int b = 30; b >= 0; b--) begin
      frm[1 + 2*(30-b)] = MASK[b] ? ~(cx[b] | cx[b+1]) : 1'b0;
      frm[2 + 2*(30-b)] = ~cx[b];
    end
    frm[63] = 1'b0;
  endtask

  task automatic play();
    for (int k = 0; k < 64; k++) drive(frm[k], SLOT_CYC);
  endtask

  task automatic t_reset();
    check(code == 31'h0, "R1 code", code, 0);
    check(!valid && !error, "R1 strobes", {valid, error}, 0);
  endtask

  task automatic t_good(input logic [30:0] c, input string req);
    int v0, e0;
    v0 = n_valid; e0 = n_err;
    build(c); play(); drive(1'b0, 3*SLOT_CYC);
    check(n_valid == v0 + 1, {req, " R6 one valid"}, n_valid - v0, 1);
    check(cap == c && code == c, {req, " R3 code"}, cap, c);
    check(n_err == e0, {req, " R5 no error"}, n_err - e0, 0);
  endtask

  task automatic t_fault(input int idx, input logic lvl, input string req);
    int v0, e0;
    logic [30:0] c0;
    v0 = n_valid; e0 = n_err; c0 = code;
    build(31'h0); frm[idx] = lvl; play(); drive(1'b0, 2*SLOT_CYC);
    check(n_err == e0 + 1, {req, " error once"}, n_err - e0, 1);
    check(n_valid == v0, {req, " no valid"}, n_valid - v0, 0);
    check(code == c0, {req, " R9 code held"}, code, c0);
    drive(1'b0, GAP*CPU + 2*SLOT_CYC);
  endtask

  task automatic t_err_hold(input logic use_abort, input logic [30:0] c);
    int v0, e0;
    v0 = n_valid; e0 = n_err;
    build(31'h0); frm[3] = 1'b1; play(); drive(1'b0, 2*SLOT_CYC);
    if (use_abort) begin abort = 1'b1; @(negedge clk); abort = 1'b0; end
    build(c); play(); drive(1'b0, 3*SLOT_CYC);
    if (use_abort) begin
      check(n_valid == v0 + 1 && cap == c, "R8 decode after abort", cap, c);
    end else begin
      check(n_valid == v0, "R7 frame ignored in error", n_valid - v0, 0);
    end
    check(n_err == e0 + 1, "R7 single error", n_err - e0, 1);
    drive(1'b0, GAP*CPU + 2*SLOT_CYC);
  endtask

  task automatic t_glitch();
    int v0, e0;
    v0 = n_valid; e0 = n_err;
    drive(1'b1, 3*CPU); drive(1'b0, 4*SLOT_CYC);
    check(n_valid == v0 && n_err == e0, "R2 glitch no strobe", n_valid - v0 + n_err - e0, 0);
    t_good(31'h0F0F0F0F, "R2 after glitch");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    drive(1'b0, 4*SLOT_CYC);
    t_good(31'h12345678, "mixed");
    t_good(31'h7FFFFFFF, "ones");
    t_good(31'h00000000, "zeros");
    t_good(31'h2AAAAAAA, "alternating");
    t_fault(3, 1'b1, "R4 nonchk pulse");
    t_good(31'h5A5A5A5A, "R7 recovered");
    t_fault(11, 1'b0, "R5 check mismatch");
    t_fault(63, 1'b1, "R6 closing pulse");
    t_err_hold(1'b0, 31'h0);
    t_good(31'h3C3C3C3C, "R7 after gap");
    t_err_hold(1'b1, 31'h0F0F0F0F);
    t_glitch();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule